// File: doc/BRIEF.md
# Dual Belt Operand Store

This block keeps the operand storage for a machine that has no register file. Operands live on two belts, a fast one and a slow one. Every stored entry carries a 32-bit value and a 5-bit condition tag (carry, signed overflow, zero, transient, invalid), so each value holds its own flags and there is no global flags register. Execution units drop results onto the front of a belt. Older entries move one step back, and the oldest entry drops off the far end.

Three consumers read through combinational ports over one 6-bit operand address space. Each address selects a belt and a position on it. The top two positions of each belt are not storage: they return fixed constants or fixed tags. Three producers (two ALUs and a flow unit) may each drop zero to two results per cycle onto either belt. All drops of a cycle land at the clock edge in a fixed unit order, so every read in the cycle sees the contents from before that cycle.

A canonicalise command rebuilds one belt in a single edge. It takes a short list of operand addresses, and the entries they select become the new front of that belt. Every other position on that belt becomes invalid.

Top module: `belt_store`

## Requirements
- R1: Address bit 5 selects the belt (0 fast, 1 slow) and bits 4:0 select the position. Positions 0 to 29 return the stored entry, position 0 being the newest.
- R2: Fast position 30 reads as value 0 with only the zero bit set (tag 5'b00100). Fast position 31 reads as value 1 with tag 0. Tag bits are: 4 invalid, 3 transient, 2 zero, 1 signed overflow, 0 carry.
- R3: Slow position 30 (address 62) reads as value 0 with tag 5'b10000 (invalid). Slow position 31 (address 63) reads as value 0 with tag 5'b01000 (transient).
- R4: After reset, every stored position on both belts reads as value 0 with tag 5'b10000.
- R5: Each dropped entry goes to position 0 of its belt and moves the older entries up one position. The entry pushed past position 29 is lost. A cycle with no drops and no canonicalise to a belt leaves that belt unchanged.
- R6: Drops within one cycle retire in this order: ALU 0, then ALU 1, then the flow unit (unit indices 0, 1, 2). The last entry retired ends up at position 0.
- R7: Reads always return the contents from before the current cycle. Drops presented in a cycle become visible only after the next rising clock edge.
- R8: Inside one unit, slot 0 retires before slot 1. When a unit drops two results, its slot 1 entry therefore lands one position nearer the front than its slot 0 entry.
- R9: A canonicalise with count k (0 to 4) loads positions 0 to k-1 of the selected belt with the entries that its addresses 0 to k-1 read from the pre-cycle view. Every other position on that belt becomes invalid (value 0, tag 5'b10000).
- R10: Canonicalise overrides any drops to the same belt in that cycle. Drops to the other belt still retire.
- R11: Each unit's drop count selects how many of its slots retire, and a count of 3 is handled as 2. Its belt select picks fast (0) or slow (1) for all of its drops that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 3×6 | Operand address for each read port |
| rd_val_o | output | 3×32 | Value read by each port |
| rd_tag_o | output | 3×5 | Tag read by each port |
| drop_cnt_i | input | 3×2 | Number of results each unit drops this cycle |
| drop_belt_i | input | 3 | Target belt for each unit (0 fast, 1 slow) |
| drop_val_i | input | 3×2×32 | Result values for each unit, slot 0 and slot 1 |
| drop_tag_i | input | 3×2×5 | Result tags for each unit, slot 0 and slot 1 |
| canon_en_i | input | 1 | Canonicalise request |
| canon_belt_i | input | 1 | Belt to canonicalise (0 fast, 1 slow) |
| canon_cnt_i | input | 3 | Number of canonicalise arguments, 0 to 4 |
| canon_addr_i | input | 4×6 | Operand addresses of the canonicalise arguments |

## Verification
The assertions check the following on every cycle of every belt:
- a single drop moves the old front entry to position 1;
- an idle belt does not change;
- a canonicalise puts its first argument at the front;
- a canonicalise always leaves the last position invalid.

Other behaviours need the bench's scenarios. These are the full retire order across units and slots, the reset contents, the constant addresses, the loss of entries at the end of a belt, reads taken before an edge, and canonicalise overriding drops. The bench compares all 64 addresses against its own model after every step.

// File: rtl/belt_pkg.sv
package belt_pkg;
  localparam int VAL_W = 32;
  localparam int TAG_W = 5;

  localparam int TAG_INV   = 4;
  localparam int TAG_TRN   = 3;
  localparam int TAG_ZERO  = 2;
  localparam int TAG_OVF   = 1;
  localparam int TAG_CARRY = 0;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [VAL_W-1:0] val;
  } entry_t;

  localparam entry_t ENT_INV   = '{tag: 5'b10000, val: '0};
  localparam entry_t ENT_TRN   = '{tag: 5'b01000, val: '0};
  localparam entry_t ENT_ZERO  = '{tag: 5'b00100, val: '0};
  localparam entry_t ENT_ONE   = '{tag: 5'b00000, val: 32'd1};
endpackage

// File: rtl/belt_read_port.sv
module belt_read_port import belt_pkg::*; #(
  parameter int DEPTH = 30,
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 1
) (
  input  entry_t [DEPTH-1:0] fast_i,
  input  entry_t [DEPTH-1:0] slow_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output entry_t             ent_o
);
  localparam logic [IDX_W-1:0] K0_IDX = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] K1_IDX = IDX_W'(DEPTH + 1);

  logic [IDX_W-1:0] idx;
  logic             sel_slow;

  assign idx      = addr_i[IDX_W-1:0];
  assign sel_slow = addr_i[ADDR_W-1];

  always_comb begin
    if (idx < K0_IDX)       ent_o = sel_slow ? slow_i[idx] : fast_i[idx];
    else if (idx == K0_IDX) ent_o = sel_slow ? ENT_INV : ENT_ZERO;
    else if (idx == K1_IDX) ent_o = sel_slow ? ENT_TRN : ENT_ONE;
    else                    ent_o = ENT_INV;
  end
endmodule

// File: rtl/belt_bank.sv
module belt_bank import belt_pkg::*; #(
  parameter int DEPTH = 30,
  parameter int N_UNITS = 3,
  parameter int MAX_DROPS = 2,
  parameter int N_CANON = 4,
  parameter bit BELT_ID = 1'b0,
  localparam int CNT_W = $clog2(MAX_DROPS + 1),
  localparam int CC_W = $clog2(N_CANON + 1)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic   [N_UNITS-1:0][CNT_W-1:0]       drop_cnt_i,
  input  logic   [N_UNITS-1:0]                  drop_sel_i,
  input  entry_t [N_UNITS-1:0][MAX_DROPS-1:0]   drop_ent_i,
  input  logic                                  canon_take_i,
  input  logic   [CC_W-1:0]                     canon_cnt_i,
  input  entry_t [N_CANON-1:0]                  canon_ent_i,
  output entry_t [DEPTH-1:0]                    belt_o
);
  localparam int N_IN = N_UNITS * MAX_DROPS;
  localparam int LW = $clog2(N_IN + 1);

  entry_t [DEPTH-1:0] belt_q, belt_d;
  entry_t [N_IN-1:0]  list;
  logic   [LW-1:0]    n;

  // Compact this belt's drops in retire order: unit order, slot order.
  always_comb begin
    list = '0;
    n    = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      for (int s = 0; s < MAX_DROPS; s++) begin
        if (drop_sel_i[u] == BELT_ID && s < int'(drop_cnt_i[u])) begin
          list[n] = drop_ent_i[u][s];
          n = n + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (canon_take_i) begin
      for (int j = 0; j < DEPTH; j++) belt_d[j] = ENT_INV;
      for (int k = 0; k < N_CANON; k++)
        if (k < int'(canon_cnt_i)) belt_d[k] = canon_ent_i[k];
    end else begin
      // Last retired lands at position 0.
      for (int j = 0; j < DEPTH; j++) begin
        if (j < int'(n)) belt_d[j] = list[int'(n) - 1 - j];
        else             belt_d[j] = belt_q[j - int'(n)];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) belt_q[j] <= ENT_INV;
    end else begin
      belt_q <= belt_d;
    end
  end

  assign belt_o = belt_q;

  assert_shift_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!canon_take_i && n == LW'(1)) |=> (belt_q[1] == $past(belt_q[0]) && belt_q[0] == $past(list[0])));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!canon_take_i && n == '0) |=> $stable(belt_q));

  assert_canon_front_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (canon_take_i && canon_cnt_i != '0) |=> belt_q[0] == $past(canon_ent_i[0]));

  assert_canon_tail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    canon_take_i |=> belt_q[DEPTH-1].tag[TAG_INV]);
endmodule

// File: rtl/belt_store.sv
module belt_store import belt_pkg::*; #(
  parameter int DEPTH = 30,
  parameter int N_UNITS = 3,
  parameter int MAX_DROPS = 2,
  parameter int N_RD = 3,
  parameter int N_CANON = 4,
  localparam int ADDR_W = $clog2(DEPTH + 2) + 1,
  localparam int CNT_W = $clog2(MAX_DROPS + 1),
  localparam int CC_W = $clog2(N_CANON + 1)
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic [N_RD-1:0][ADDR_W-1:0]                 rd_addr_i,
  output logic [N_RD-1:0][VAL_W-1:0]                  rd_val_o,
  output logic [N_RD-1:0][TAG_W-1:0]                  rd_tag_o,
  input  logic [N_UNITS-1:0][CNT_W-1:0]               drop_cnt_i,
  input  logic [N_UNITS-1:0]                          drop_belt_i,
  input  logic [N_UNITS-1:0][MAX_DROPS-1:0][VAL_W-1:0] drop_val_i,
  input  logic [N_UNITS-1:0][MAX_DROPS-1:0][TAG_W-1:0] drop_tag_i,
  input  logic                                        canon_en_i,
  input  logic                                        canon_belt_i,
  input  logic [CC_W-1:0]                             canon_cnt_i,
  input  logic [N_CANON-1:0][ADDR_W-1:0]              canon_addr_i
);
  entry_t [1:0][DEPTH-1:0]                 belt_q;
  entry_t [N_UNITS-1:0][MAX_DROPS-1:0]     drop_ent;
  entry_t [N_RD-1:0]                       rd_ent;
  entry_t [N_CANON-1:0]                    canon_ent;

  always_comb begin
    for (int u = 0; u < N_UNITS; u++)
      for (int s = 0; s < MAX_DROPS; s++)
        drop_ent[u][s] = '{tag: drop_tag_i[u][s], val: drop_val_i[u][s]};
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    belt_read_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_port (
      .fast_i(belt_q[0]),
      .slow_i(belt_q[1]),
      .addr_i(rd_addr_i[r]),
      .ent_o (rd_ent[r])
    );
    assign rd_val_o[r] = rd_ent[r].val;
    assign rd_tag_o[r] = rd_ent[r].tag;
  end

  // Canonicalise arguments read the pre-cycle view.
  for (genvar c = 0; c < N_CANON; c++) begin : g_canon
    belt_read_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_port (
      .fast_i(belt_q[0]),
      .slow_i(belt_q[1]),
      .addr_i(canon_addr_i[c]),
      .ent_o (canon_ent[c])
    );
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    belt_bank #(
      .DEPTH(DEPTH), .N_UNITS(N_UNITS), .MAX_DROPS(MAX_DROPS),
      .N_CANON(N_CANON), .BELT_ID(1'(b))
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .drop_cnt_i  (drop_cnt_i),
      .drop_sel_i  (drop_belt_i),
      .drop_ent_i  (drop_ent),
      .canon_take_i(canon_en_i && (canon_belt_i == 1'(b))),
      .canon_cnt_i (canon_cnt_i),
      .canon_ent_i (canon_ent),
      .belt_o      (belt_q[b])
    );
  end
endmodule

// File: tb/belt_store_tb.sv
`timescale 1ns/1ps
module belt_store_tb_top;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0][5:0]   rd_addr_i = '0;
  logic [2:0][31:0]  rd_val_o;
  logic [2:0][4:0]   rd_tag_o;
  logic [2:0][1:0]   drop_cnt_i = '0;
  logic [2:0]        drop_belt_i = '0;
  logic [2:0][1:0][31:0] drop_val_i = '0;
  logic [2:0][1:0][4:0]  drop_tag_i = '0;
  logic              canon_en_i = 1'b0;
  logic              canon_belt_i = 1'b0;
  logic [2:0]        canon_cnt_i = '0;
  logic [3:0][5:0]   canon_addr_i = '0;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  logic [36:0] m [2][30];
  localparam logic [36:0] INV = {5'b10000, 32'd0};

  belt_store dut_i (.*);

  function automatic logic [36:0] exp_rd(input int a);
    int b = a / 32;
    int i = a % 32;
    if (i < 30) return m[b][i];
    if (i == 30) return (b == 0) ? {5'b00100, 32'd0} : {5'b10000, 32'd0};
    return (b == 0) ? {5'b00000, 32'd1} : {5'b01000, 32'd0};
  endfunction

  task automatic tick();
    #2.5 clk_i = 1'b1;
    #2.5 clk_i = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 64; a += 3) begin
      for (int p = 0; p < 3; p++) rd_addr_i[p] = 6'((a + p) % 64);
      #1;
      for (int p = 0; p < 3; p++) begin
        if (a + p < 64) begin
          int ad = a + p;
          string lbl = req;
          logic [36:0] e = exp_rd(ad);
          logic [36:0] g = {rd_tag_o[p], rd_val_o[p]};
          if (ad % 32 >= 30) lbl = (ad < 32) ? "R2" : "R3";
          checks++;
          if (g !== e) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", lbl, ad, g, e);
          end
        end
      end
    end
  endtask

  task automatic set_drop(input int u, input bit b, input int c);
    drop_belt_i[u] = b;
    drop_cnt_i[u]  = 2'(c);
    for (int s = 0; s < 2; s++) begin
      seq++;
      drop_val_i[u][s] = 32'h1000_0000 * (u + 1) + 32'(seq);
      drop_tag_i[u][s] = 5'(seq * 7);
    end
  endtask

  task automatic set_canon(input bit b, input int c, input int a0, input int a1,
                           input int a2, input int a3);
    canon_en_i = 1'b1; canon_belt_i = b; canon_cnt_i = 3'(c);
    canon_addr_i[0] = 6'(a0); canon_addr_i[1] = 6'(a1);
    canon_addr_i[2] = 6'(a2); canon_addr_i[3] = 6'(a3);
  endtask

  // Model update from requirements, then edge, then clear inputs.
  task automatic step();
    logic [36:0] nm [2][30];
    for (int b = 0; b < 2; b++) begin
      if (canon_en_i && canon_belt_i == 1'(b)) begin
        for (int j = 0; j < 30; j++) nm[b][j] = INV;
        for (int k = 0; k < int'(canon_cnt_i) && k < 4; k++) nm[b][k] = exp_rd(int'(canon_addr_i[k]));
      end else begin
        for (int j = 0; j < 30; j++) nm[b][j] = m[b][j];
        for (int u = 0; u < 3; u++) begin
          int n = (drop_cnt_i[u] > 2) ? 2 : int'(drop_cnt_i[u]);
          if (drop_belt_i[u] == 1'(b))
            for (int s = 0; s < n; s++) begin
              for (int j = 29; j > 0; j--) nm[b][j] = nm[b][j-1];
              nm[b][0] = {drop_tag_i[u][s], drop_val_i[u][s]};
            end
        end
      end
    end
    tick();
    for (int b = 0; b < 2; b++) for (int j = 0; j < 30; j++) m[b][j] = nm[b][j];
    drop_cnt_i = '0; canon_en_i = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int j = 0; j < 30; j++) m[b][j] = INV;
    tick(); tick();
    rst_ni = 1'b1;
    sweep("R4");

    set_drop(0, 0, 1); step(); sweep("R5");
    set_drop(1, 1, 2); step(); sweep("R8");
    set_drop(0, 0, 2); set_drop(1, 0, 1); set_drop(2, 0, 2); step(); sweep("R6");
    set_drop(2, 1, 1); set_drop(0, 0, 3); step(); sweep("R11");

    set_drop(0, 1, 2); set_drop(1, 0, 2);
    sweep("R7");
    step(); sweep("R7");

    for (int i = 0; i < 35; i++) begin set_drop(2, 0, 1); step(); end
    sweep("R5");
    step(); sweep("R5");

    set_canon(0, 3, 33, 5, 31, 0); step(); sweep("R9");
    set_canon(1, 0, 0, 0, 0, 0); step(); sweep("R9");
    set_drop(0, 1, 2); set_drop(1, 1, 1); step();
    set_canon(1, 4, 1, 0, 63, 30); set_drop(0, 1, 2); set_drop(1, 0, 2); set_drop(2, 1, 1);
    step(); sweep("R10");

    for (int i = 0; i < 200; i++) begin
      for (int u = 0; u < 3; u++) begin
        set_drop(u, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
        drop_val_i[u][0] = $urandom(); drop_tag_i[u][1] = 5'($urandom());
      end
      if ($urandom_range(0, 9) == 0)
        set_canon(1'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
                  int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
                  int'($urandom_range(0, 63)), int'($urandom_range(0, 63)));
      step();
      if (i % 10 == 0) sweep("R1 R6");
    end
    sweep("R1 R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule